// File: doc/BRIEF.md
# DMA Channel Control State Machine

This block holds the run control of a bank of DMA channels. It does not move data. It sits above a per-channel address sequencer. For every channel it records the programmed control settings, follows a four-state machine, and tells the sequencer when to run and when to reload its working register set. Request lines are level-sensitive. A registered copy of the lines, the request bitmap, lets the block detect a rising request. Synchronized channels then run or stall according to the granularity they were programmed with.

At the end of a block the channel applies one of four policies:
- compatibility disable, with optional linking to another channel;
- disable when auto-initialization is off;
- reload and continue when auto-initialization is on and repeat or end-of-program is set;
- otherwise, park and wait for reprogramming.

Writes to the geometry registers (counts, addresses, indexes) arm a lazy reload that is applied at the next activation. The parameter `WIDE_CFG` selects 9 channels and 32 request lines (0) or 16 channels and 64 request lines (1).

States of each channel:
- **IDLE**: disabled.
- **WAIT**: enabled, but not running.
- **ACTIVE**: running.
- **REPROG**: enabled and parked until new programming arrives.

Transitions:
- **enable**: IDLE to ACTIVE or WAIT.
- **trigger**: WAIT to ACTIVE.
- **park**: ACTIVE to WAIT.
- **finish**: ACTIVE to IDLE.
- **hold**: ACTIVE to REPROG.
- **resume**: REPROG to ACTIVE or WAIT.
- **disable**: any state to IDLE.
- **clear**: any state to IDLE, on reset or soft reset.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After `rst_n` low, or in the cycle after a `soft_rst_i` pulse, every channel is IDLE with `run_o`, `sync_o`, `load_o` and `link_o` all zero. The request bitmap is also cleared, so a line still held high counts as a new rising request.
- R2: An enable command to an IDLE channel pulses its `load_o` and clears its update-pending flag. The channel goes to ACTIVE if its sync line field is 0 (unsynchronized) or the selected request line is high; otherwise it goes to WAIT. An enable command to a channel that is not IDLE has no effect.
- R3: A WAIT channel with a nonzero sync line goes ACTIVE on the cycle its request line rises from 0 to 1 relative to the request bitmap.
- R4: A write strobe on `geo_we_i` sets that channel's update-pending flag. The next trigger from WAIT pulses `load_o` and clears the flag. A trigger with no flag pending gives no load pulse.
- R5: `sync_o[i]` is high exactly while channel i is ACTIVE with a nonzero sync line.
- R6: On an event for an ACTIVE synchronized channel, the channel parks to WAIT according to its granularity bits:
  - frame bit 0 and block bit 0: on element done;
  - frame bit 1 and block bit 0: on frame end;
  - both bits 1: on packet end.

  Other events leave the channel ACTIVE.
- R7: The park of R6 is suppressed while the channel's selected request line is high.
- R8: On block end with the compatibility bit set, the channel goes IDLE. If its link-enable bit is set and its link field is a valid channel number, the named channel receives an enable in the same cycle and `link_o` pulses for that channel.
- R9: On block end with the compatibility bit clear: if auto-init is clear, the channel goes IDLE. If auto-init is set and repeat or end-of-program is set, `load_o` pulses and the channel stays ACTIVE, unless the R6/R7 park applies.
- R10: On block end with the compatibility bit clear, auto-init set and neither repeat nor end-of-program set, the channel enters REPROG. A control write to that channel with end-of-program set pulses `load_o` and resumes it as in R2. Other stimulus leaves it parked.
- R11: A disable command sends the addressed channel to IDLE from any state. It takes priority over every other stimulus except soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst_i | input | 1 | Global soft reset pulse |
| req_i | input | NREQ | Level-sensitive request lines |
| en_valid_i | input | 1 | Enable command for `cmd_ch_i` |
| dis_valid_i | input | 1 | Disable command for `cmd_ch_i` |
| cmd_ch_i | input | CHW | Channel addressed by the command |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_ch_i | input | CHW | Channel of the control write |
| cfg_sync_i | input | REQW | Sync request line, 0 = unsynchronized |
| cfg_fsync_i | input | 1 | Frame granularity bit |
| cfg_bsync_i | input | 1 | Block/packet granularity bit |
| cfg_compat_i | input | 1 | Compatibility-disable end-of-block policy |
| cfg_link_en_i | input | 1 | Link enable |
| cfg_link_ch_i | input | CHW | Link target channel |
| cfg_autoinit_i | input | 1 | Auto-initialization |
| cfg_repeat_i | input | 1 | Repeat |
| cfg_endprog_i | input | 1 | End-of-program |
| geo_we_i | input | 1 | Geometry register write strobe |
| geo_ch_i | input | CHW | Channel of the geometry write |
| ev_valid_i | input | 1 | Sequencer event valid |
| ev_ch_i | input | CHW | Channel of the event |
| ev_elem_i | input | 1 | Element done |
| ev_frame_i | input | 1 | Frame end |
| ev_pkt_i | input | 1 | Packet end |
| ev_block_i | input | 1 | Block end |
| run_o | output | NCH | Channel ACTIVE |
| sync_o | output | NCH | SYNC status per channel |
| load_o | output | NCH | Reload active set pulse |
| link_o | output | NCH | Enable-by-link pulse |

## Verification
Every stimulus is sampled on a rising edge, and all four outputs settle for that edge in one cycle. `run_o` and `sync_o` follow the new state. `load_o` and `link_o` are registered pulses that last exactly the cycle after the edge. A link enable reaches its target at the same edge as the block end that caused it.

The bench drives inputs just after a falling edge and samples outputs at the following falling edge. It compares them with a cycle-stepped reference model. Directed sequences cover parking, blocked parking, lazy reload, linking, every end-of-block policy and soft reset.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_WAIT   = 2'd1,
        CH_ACTIVE = 2'd2,
        CH_REPROG = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic fsync;
        logic bsync;
        logic compat;
        logic link_en;
        logic autoinit;
        logic rpt;
        logic endprog;
    } ch_mode_t;

    function automatic int chan_count(bit wide);
        return wide ? 16 : 9;
    endfunction

    function automatic int line_count(bit wide);
        return wide ? 64 : 32;
    endfunction

endpackage

// File: rtl/dmac_req_capture.sv
module dmac_req_capture #(
    parameter int NREQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [NREQ-1:0] req_i,
    output logic [NREQ-1:0] rise_o
);
    logic [NREQ-1:0] bmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) bmp_q <= '0;
        else                 bmp_q <= req_i;
    end

    assign rise_o = req_i & ~bmp_q;
endmodule

// File: rtl/dmac_link_route.sv
module dmac_link_route #(
    parameter int NCH = 9,
    parameter int CHW = 4
) (
    input  logic [NCH-1:0]     link_req_i,
    input  logic [NCH*CHW-1:0] link_tgt_i,
    input  logic [NCH-1:0]     en_cmd_i,
    output logic [NCH-1:0]     en_all_o,
    output logic [NCH-1:0]     link_hit_o
);
    always_comb begin
        link_hit_o = '0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = 0; j < NCH; j++) begin
                if (link_req_i[i] && link_tgt_i[i*CHW +: CHW] == CHW'(j))
                    link_hit_o[j] = 1'b1;
            end
        end
    end

    assign en_all_o = en_cmd_i | link_hit_o;
endmodule

// File: rtl/dmac_chan_fsm.sv
module dmac_chan_fsm
    import dmac_pkg::*;
#(
    parameter int NREQ = 32,
    parameter int CHW  = 4,
    localparam int REQW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic            en_i,
    input  logic            dis_i,
    input  logic            cfg_we_i,
    input  logic [REQW-1:0] cfg_line_i,
    input  logic [CHW-1:0]  cfg_lch_i,
    input  ch_mode_t        cfg_mode_i,
    input  logic            geo_we_i,
    input  logic            ev_hit_i,
    input  logic            ev_elem_i,
    input  logic            ev_frame_i,
    input  logic            ev_pkt_i,
    input  logic            ev_block_i,
    input  logic [NREQ-1:0] lvl_i,
    input  logic [NREQ-1:0] rise_i,
    output logic            run_o,
    output logic            sync_o,
    output logic            load_o,
    output logic            link_req_o,
    output logic [CHW-1:0]  link_tgt_o
);
    ch_state_e       st_q, st_d;
    logic [REQW-1:0] line_q;
    logic [CHW-1:0]  lch_q;
    ch_mode_t        mode_q;
    logic            pend_q, load_q, load_d;

    logic synced, lvl_hi, rise_hi, gran_hit, may_park;
    ch_state_e start_st;

    assign synced   = |line_q;
    assign lvl_hi   = lvl_i[line_q];
    assign rise_hi  = rise_i[line_q];
    assign gran_hit = (!mode_q.fsync && !mode_q.bsync && ev_elem_i) ||
                      ( mode_q.fsync && !mode_q.bsync && ev_frame_i) ||
                      ( mode_q.fsync &&  mode_q.bsync && ev_pkt_i);
    assign may_park = synced && !lvl_hi;
    assign start_st = (!synced || lvl_hi) ? CH_ACTIVE : CH_WAIT;

    // next-state decision
    always_comb begin
        st_d       = st_q;
        load_d     = 1'b0;
        link_req_o = 1'b0;
        if (soft_rst_i) begin
            st_d = CH_IDLE;
        end else if (dis_i) begin
            st_d = CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE: if (en_i) begin
                    load_d = 1'b1;
                    st_d   = start_st;
                end
                CH_WAIT: if (synced && rise_hi) begin
                    st_d   = CH_ACTIVE;
                    load_d = pend_q;
                end
                CH_ACTIVE: if (ev_hit_i) begin
                    if (ev_block_i) begin
                        if (mode_q.compat) begin
                            st_d       = CH_IDLE;
                            link_req_o = mode_q.link_en;
                        end else if (!mode_q.autoinit) begin
                            st_d = CH_IDLE;
                        end else if (mode_q.rpt || mode_q.endprog) begin
                            load_d = 1'b1;
                            if (gran_hit && may_park) st_d = CH_WAIT;
                        end else begin
                            st_d = CH_REPROG;
                        end
                    end else if (gran_hit && may_park) begin
                        st_d = CH_WAIT;
                    end
                end
                CH_REPROG: if (cfg_we_i && cfg_mode_i.endprog) begin
                    load_d = 1'b1;
                    st_d   = start_st;
                end
            endcase
        end
    end

    // state and settings registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_IDLE;
            pend_q <= 1'b0;
            line_q <= '0;
            lch_q  <= '0;
            mode_q <= '0;
        end else begin
            st_q <= st_d;
            if (soft_rst_i)    pend_q <= 1'b0;
            else if (geo_we_i) pend_q <= 1'b1;
            else if (load_d)   pend_q <= 1'b0;
            if (cfg_we_i) begin
                line_q <= cfg_line_i;
                lch_q  <= cfg_lch_i;
                mode_q <= cfg_mode_i;
            end
        end
    end

    // registered pulse output
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_d;
    end

    assign run_o      = (st_q == CH_ACTIVE);
    assign sync_o     = run_o && synced;
    assign load_o     = load_q;
    assign link_tgt_o = lch_q;
endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
    import dmac_pkg::*;
#(
    parameter bit WIDE_CFG = 1'b0,
    localparam int NCH  = chan_count(WIDE_CFG),
    localparam int NREQ = line_count(WIDE_CFG),
    localparam int CHW  = $clog2(NCH),
    localparam int REQW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic [NREQ-1:0] req_i,
    input  logic            en_valid_i,
    input  logic            dis_valid_i,
    input  logic [CHW-1:0]  cmd_ch_i,
    input  logic            cfg_we_i,
    input  logic [CHW-1:0]  cfg_ch_i,
    input  logic [REQW-1:0] cfg_sync_i,
    input  logic            cfg_fsync_i,
    input  logic            cfg_bsync_i,
    input  logic            cfg_compat_i,
    input  logic            cfg_link_en_i,
    input  logic [CHW-1:0]  cfg_link_ch_i,
    input  logic            cfg_autoinit_i,
    input  logic            cfg_repeat_i,
    input  logic            cfg_endprog_i,
    input  logic            geo_we_i,
    input  logic [CHW-1:0]  geo_ch_i,
    input  logic            ev_valid_i,
    input  logic [CHW-1:0]  ev_ch_i,
    input  logic            ev_elem_i,
    input  logic            ev_frame_i,
    input  logic            ev_pkt_i,
    input  logic            ev_block_i,
    output logic [NCH-1:0]  run_o,
    output logic [NCH-1:0]  sync_o,
    output logic [NCH-1:0]  load_o,
    output logic [NCH-1:0]  link_o
);
    logic [NREQ-1:0]    rise;
    logic [NCH-1:0]     en_cmd, en_all, link_req, link_hit;
    logic [NCH*CHW-1:0] link_tgt;
    ch_mode_t           mode_w;

    always_comb begin
        mode_w.fsync    = cfg_fsync_i;
        mode_w.bsync    = cfg_bsync_i;
        mode_w.compat   = cfg_compat_i;
        mode_w.link_en  = cfg_link_en_i;
        mode_w.autoinit = cfg_autoinit_i;
        mode_w.rpt      = cfg_repeat_i;
        mode_w.endprog  = cfg_endprog_i;
    end

    dmac_req_capture #(.NREQ(NREQ)) req_cap_i (
        .clk(clk), .rst_n(rst_n), .clr_i(soft_rst_i),
        .req_i(req_i), .rise_o(rise)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign en_cmd[c] = en_valid_i && (cmd_ch_i == CHW'(c));
        dmac_chan_fsm #(.NREQ(NREQ), .CHW(CHW)) ch_i (
            .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
            .en_i(en_all[c]),
            .dis_i(dis_valid_i && (cmd_ch_i == CHW'(c))),
            .cfg_we_i(cfg_we_i && (cfg_ch_i == CHW'(c))),
            .cfg_line_i(cfg_sync_i), .cfg_lch_i(cfg_link_ch_i),
            .cfg_mode_i(mode_w),
            .geo_we_i(geo_we_i && (geo_ch_i == CHW'(c))),
            .ev_hit_i(ev_valid_i && (ev_ch_i == CHW'(c))),
            .ev_elem_i(ev_elem_i), .ev_frame_i(ev_frame_i),
            .ev_pkt_i(ev_pkt_i), .ev_block_i(ev_block_i),
            .lvl_i(req_i), .rise_i(rise),
            .run_o(run_o[c]), .sync_o(sync_o[c]), .load_o(load_o[c]),
            .link_req_o(link_req[c]),
            .link_tgt_o(link_tgt[c*CHW +: CHW])
        );
    end

    dmac_link_route #(.NCH(NCH), .CHW(CHW)) route_i (
        .link_req_i(link_req), .link_tgt_i(link_tgt), .en_cmd_i(en_cmd),
        .en_all_o(en_all), .link_hit_o(link_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) link_o <= '0;
        else        link_o <= link_hit;
    end
endmodule

// File: rtl/dmac_chan_ctrl_chk.sv
module dmac_chan_ctrl_chk #(
    parameter int NCH = 9,
    parameter int CHW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           soft_rst_i,
    input logic           dis_valid_i,
    input logic [CHW-1:0] cmd_ch_i,
    input logic [NCH-1:0] run_o,
    input logic [NCH-1:0] sync_o,
    input logic [NCH-1:0] load_o,
    input logic [NCH-1:0] link_o
);
    // R1
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (run_o == '0 && load_o == '0 && link_o == '0));

    // R5
    sync_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o & ~run_o) == '0);

    // R8
    link_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_o));

    for (genvar i = 0; i < NCH; i++) begin : g_dis
        // R11
        disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_valid_i && cmd_ch_i == CHW'(i)) |=> !run_o[i]);
    end
endmodule

bind dmac_chan_ctrl dmac_chan_ctrl_chk #(.NCH(NCH), .CHW(CHW)) chk_i (.*);

// File: tb/dmac_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_tb_top;
    localparam int NCH = 9, NREQ = 32, CHW = 4, REQW = 5;

    logic clk = 0, rst_n = 0, soft_rst_i = 0;
    logic [NREQ-1:0] req_i = '0;
    logic en_valid_i = 0, dis_valid_i = 0, cfg_we_i = 0, geo_we_i = 0, ev_valid_i = 0;
    logic [CHW-1:0] cmd_ch_i = '0, cfg_ch_i = '0, cfg_link_ch_i = '0, geo_ch_i = '0, ev_ch_i = '0;
    logic [REQW-1:0] cfg_sync_i = '0;
    logic cfg_fsync_i = 0, cfg_bsync_i = 0, cfg_compat_i = 0, cfg_link_en_i = 0;
    logic cfg_autoinit_i = 0, cfg_repeat_i = 0, cfg_endprog_i = 0;
    logic ev_elem_i = 0, ev_frame_i = 0, ev_pkt_i = 0, ev_block_i = 0;
    logic [NCH-1:0] run_o, sync_o, load_o, link_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dmac_chan_ctrl #(.WIDE_CFG(1'b0)) dut_i (.*);

    // reference model: 0 idle, 1 wait, 2 active, 3 reprog
    int m_st[NCH];
    bit m_pend[NCH];
    int m_line[NCH], m_lch[NCH];
    bit m_fs[NCH], m_bs[NCH], m_cp[NCH], m_le[NCH], m_ai[NCH], m_rp[NCH], m_ep[NCH];
    bit [NREQ-1:0] m_bmp;
    bit [NCH-1:0] e_run, e_sync, e_load, e_link;

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_st[i] = 0; m_pend[i] = 0; m_line[i] = 0; m_lch[i] = 0;
            m_fs[i] = 0; m_bs[i] = 0; m_cp[i] = 0; m_le[i] = 0;
            m_ai[i] = 0; m_rp[i] = 0; m_ep[i] = 0;
        end
        m_bmp = '0; e_run = '0; e_sync = '0; e_load = '0; e_link = '0;
    endtask

    function automatic bit park_ok(int i, bit hi);
        bit g;
        g = (!m_fs[i] && !m_bs[i] && ev_elem_i) || (m_fs[i] && !m_bs[i] && ev_frame_i) ||
            (m_fs[i] && m_bs[i] && ev_pkt_i);
        return g && (m_line[i] != 0) && !hi;
    endfunction

    task automatic model_step();
        int nst[NCH];
        bit ld[NCH];
        bit [NCH-1:0] lhit;
        lhit = '0;
        for (int i = 0; i < NCH; i++)
            if (!soft_rst_i && !(dis_valid_i && cmd_ch_i == i) && m_st[i] == 2 &&
                ev_valid_i && ev_ch_i == i && ev_block_i && m_cp[i] && m_le[i] && m_lch[i] < NCH)
                lhit[m_lch[i]] = 1;
        for (int i = 0; i < NCH; i++) begin
            bit hi, rs, en;
            hi = req_i[m_line[i]];
            rs = hi && !m_bmp[m_line[i]];
            en = (en_valid_i && cmd_ch_i == i) || lhit[i];
            nst[i] = m_st[i]; ld[i] = 0;
            if (soft_rst_i || (dis_valid_i && cmd_ch_i == i)) nst[i] = 0;
            else if (m_st[i] == 0) begin
                if (en) begin ld[i] = 1; nst[i] = (m_line[i] == 0 || hi) ? 2 : 1; end
            end else if (m_st[i] == 1) begin
                if (m_line[i] != 0 && rs) begin nst[i] = 2; ld[i] = m_pend[i]; end
            end else if (m_st[i] == 2) begin
                if (ev_valid_i && ev_ch_i == i) begin
                    if (ev_block_i) begin
                        if (m_cp[i] || !m_ai[i]) nst[i] = 0;
                        else if (m_rp[i] || m_ep[i]) begin
                            ld[i] = 1; if (park_ok(i, hi)) nst[i] = 1;
                        end else nst[i] = 3;
                    end else if (park_ok(i, hi)) nst[i] = 1;
                end
            end else begin
                if (cfg_we_i && cfg_ch_i == i && cfg_endprog_i) begin
                    ld[i] = 1; nst[i] = (m_line[i] == 0 || hi) ? 2 : 1;
                end
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (soft_rst_i) m_pend[i] = 0;
            else if (geo_we_i && geo_ch_i == i) m_pend[i] = 1;
            else if (ld[i]) m_pend[i] = 0;
            if (cfg_we_i && cfg_ch_i == i) begin
                m_line[i] = cfg_sync_i; m_lch[i] = cfg_link_ch_i;
                m_fs[i] = cfg_fsync_i; m_bs[i] = cfg_bsync_i; m_cp[i] = cfg_compat_i;
                m_le[i] = cfg_link_en_i; m_ai[i] = cfg_autoinit_i;
                m_rp[i] = cfg_repeat_i; m_ep[i] = cfg_endprog_i;
            end
            m_st[i] = nst[i];
            e_run[i] = (nst[i] == 2);
            e_sync[i] = (nst[i] == 2) && (m_line[i] != 0);
            e_load[i] = ld[i];
        end
        e_link = lhit;
        m_bmp = soft_rst_i ? '0 : req_i;
    endtask

    task automatic chk(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_strobes();
        soft_rst_i = 0; en_valid_i = 0; dis_valid_i = 0; cfg_we_i = 0; geo_we_i = 0;
        ev_valid_i = 0; ev_elem_i = 0; ev_frame_i = 0; ev_pkt_i = 0; ev_block_i = 0;
    endtask

    // one clock: model, edge, sample at falling edge, compare
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R6 run", int'(run_o), int'(e_run));
        chk("R5 sync", int'(sync_o), int'(e_sync));
        chk("R4 load", int'(load_o), int'(e_load));
        chk("R8 link", int'(link_o), int'(e_link));
        clear_strobes();
    endtask

    task automatic cfg(int ch, int line, bit fs, bit bs, bit cp, bit le, int lch, bit ai, bit rp, bit ep);
        cfg_we_i = 1; cfg_ch_i = CHW'(ch); cfg_sync_i = REQW'(line);
        cfg_fsync_i = fs; cfg_bsync_i = bs; cfg_compat_i = cp; cfg_link_en_i = le;
        cfg_link_ch_i = CHW'(lch); cfg_autoinit_i = ai; cfg_repeat_i = rp; cfg_endprog_i = ep;
        tick();
    endtask

    task automatic enable(int ch);  en_valid_i = 1;  cmd_ch_i = CHW'(ch); tick(); endtask
    task automatic disable_ch(int ch); dis_valid_i = 1; cmd_ch_i = CHW'(ch); tick(); endtask
    task automatic event_on(int ch, bit el, bit fr, bit pk, bit bl);
        ev_valid_i = 1; ev_ch_i = CHW'(ch);
        ev_elem_i = el; ev_frame_i = fr; ev_pkt_i = pk; ev_block_i = bl;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1; n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5A_0C47));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 run", int'(run_o), 0);
        chk("R1 load", int'(load_o), 0);
        chk("R1 sync", int'(sync_o), 0);

        // R2 unsynchronized enable starts at once
        cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        enable(0);
        chk("R2 run0", run_o[0], 1); chk("R2 load0", load_o[0], 1);
        enable(0);
        chk("R2 no reload", load_o[0], 0);

        // R2 synced enable with line low waits; R3 rising edge triggers
        cfg(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        enable(1);
        chk("R2 wait1", run_o[1], 0); chk("R2 load1", load_o[1], 1);
        req_i[5] = 1; tick();
        chk("R3 run1", run_o[1], 1); chk("R5 sync1", sync_o[1], 1);
        chk("R4 no pend", load_o[1], 0);

        // R7 park blocked while high; R6 element park once low
        event_on(1, 1, 0, 0, 0);
        chk("R7 held", run_o[1], 1);
        req_i[5] = 0; tick();
        chk("R6 level only", run_o[1], 1);
        event_on(1, 1, 0, 0, 0);
        chk("R6 elem park", run_o[1], 0); chk("R5 sync clr", sync_o[1], 0);

        // R4 lazy reload
        geo_we_i = 1; geo_ch_i = 1; tick();
        req_i[5] = 1; tick();
        chk("R4 reload", load_o[1], 1); chk("R3 rerun", run_o[1], 1);

        // R6 frame granularity
        cfg(1, 5, 1, 0, 0, 0, 0, 0, 0, 0);
        req_i[5] = 0; tick();
        event_on(1, 1, 0, 0, 0);
        chk("R6 frame ignores elem", run_o[1], 1);
        event_on(1, 0, 1, 0, 0);
        chk("R6 frame park", run_o[1], 0);

        // R8 compatibility disable with link
        cfg(2, 0, 0, 0, 1, 1, 3, 0, 0, 0);
        cfg(3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        enable(2);
        event_on(2, 0, 0, 0, 1);
        chk("R8 src off", run_o[2], 0); chk("R8 tgt on", run_o[3], 1);
        chk("R8 link", int'(link_o), 8); chk("R8 tgt load", load_o[3], 1);

        // R9 auto-init off disables; auto-init with repeat reloads
        event_on(3, 0, 0, 0, 1);
        chk("R9 off", run_o[3], 0);
        cfg(4, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        enable(4);
        event_on(4, 0, 0, 0, 1);
        chk("R9 repeat run", run_o[4], 1); chk("R9 repeat load", load_o[4], 1);

        // R10 wait for reprogramming then resume
        cfg(5, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        enable(5);
        event_on(5, 0, 0, 0, 1);
        chk("R10 parked", run_o[5], 0);
        enable(5);
        chk("R10 enable ignored", run_o[5], 0);
        cfg(5, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        chk("R10 resume", run_o[5], 1); chk("R10 load", load_o[5], 1);

        // R11 disable
        disable_ch(4);
        chk("R11 off", run_o[4], 0);

        // R1 soft reset
        soft_rst_i = 1; tick();
        chk("R1 soft", int'(run_o), 0);

        // constrained random against the model
        for (int k = 0; k < 4000; k++) begin
            int a;
            a = $urandom % 20;
            if ($urandom % 4 == 0) req_i[$urandom % 4] = ~req_i[$urandom % 4];
            if (a < 4) begin
                en_valid_i = 1; cmd_ch_i = CHW'($urandom % NCH);
            end else if (a == 4) begin
                dis_valid_i = 1; cmd_ch_i = CHW'($urandom % NCH);
            end else if (a < 8) begin
                cfg_we_i = 1; cfg_ch_i = CHW'($urandom % NCH);
                cfg_sync_i = REQW'($urandom % 4);
                {cfg_fsync_i, cfg_bsync_i, cfg_compat_i, cfg_link_en_i} = 4'($urandom);
                {cfg_autoinit_i, cfg_repeat_i, cfg_endprog_i} = 3'($urandom);
                cfg_link_ch_i = CHW'($urandom % 12);
            end else if (a == 8) begin
                geo_we_i = 1; geo_ch_i = CHW'($urandom % NCH);
            end else if (a < 19) begin
                ev_valid_i = 1; ev_ch_i = CHW'($urandom % NCH);
                {ev_elem_i, ev_frame_i, ev_pkt_i} = 3'($urandom);
                ev_block_i = ($urandom % 3 == 0);
            end else if ($urandom % 10 == 0) begin
                soft_rst_i = 1;
            end
            tick();
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule